// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between a clock generator's internal dividers and its output pins. It gates a processor clock pair, a group of bus clocks, a free-running bus clock, the reference clocks and the serial-bus clock. Three active-low control pins drive it: a processor-clock stop, a bus-clock stop and a power-down. The pins may change at any time. Each one is resynchronized into the clock domain it gates, and every gate opens or closes only while its own clock is low. A stopped output therefore rests low, and the first pulse after a restart has a full high phase.

Power-down overrides both stop pins. It drops the oscillator and PLL enables and closes every gate. When power-down is released the enables return at once, but every output stays low for a parameterized number of reference-clock cycles. This delay models oscillator and PLL settling. Asserting power-down again during that delay restarts it.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_i` is high, every clock output stays low and `osc_en_o` and `pll_en_o` are low.
- R2: With `cpu_stop_ni` low and held, both `cpu_clk_o` bits are low from the fourth falling edge of `clk_cpu_i` after the pin is first sampled low.
- R3: With `pci_stop_ni` low and held, every `pci_clk_o` bit is low from the fourth falling edge of `clk_pci_i` after the pin is first sampled low, while `pci_free_o` keeps toggling.
- R4: With `pwr_dn_ni` low, `osc_en_o` and `pll_en_o` are low from the third rising edge of `clk_ref_i` after the pin is sampled low, and every clock output is held low whatever the two stop pins are.
- R5: With all three pins high, every output follows its source clock: `cpu_clk_o` follows `clk_cpu_i`, `pci_clk_o` and `pci_free_o` follow `clk_pci_i`, `ref_clk_o` follows `clk_ref_i`, and `usb_clk_o` follows `clk_usb_i`.
- R6: No high or low pulse on any clock output is shorter than half a period of its source clock, whatever the timing of the control pins.
- R7: After `osc_en_o` rises, every clock output stays low for at least `SETTLE_CYC` periods of `clk_ref_i`. Power-down asserted again during that interval restarts the wait.
- R8: The stop domains are independent. The processor stop does not stop the bus, free-running, reference or serial-bus clocks, and the bus stop does not stop the processor clocks or `pci_free_o`. Whenever any gated bus clock runs, `pci_free_o` runs as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Internal processor clock |
| clk_pci_i | input | 1 | Internal bus clock |
| clk_ref_i | input | 1 | Reference clock; also clocks the power sequencer |
| clk_usb_i | input | 1 | Internal serial-bus clock |
| rst_i | input | 1 | Synchronous active-high reset, held across edges of every clock |
| cpu_stop_ni | input | 1 | Asynchronous processor clock stop, active low |
| pci_stop_ni | input | 1 | Asynchronous bus clock stop, active low |
| pwr_dn_ni | input | 1 | Asynchronous power-down, active low |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| pci_free_o | output | 1 | Bus clock stopped only by power-down |
| ref_clk_o | output | N_REF | Gated reference clocks |
| usb_clk_o | output | 1 | Gated serial-bus clock |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
The bench toggles the control pins at random offsets from every clock and measures each edge of every output. A gate that changed while its clock was high would produce a sliver pulse, and the width monitor would flag it. Each power-up is timed from the rise of the oscillator enable. A settle counter that is short by one cycle, or that fails to restart when power-down returns mid-settle, would open the outputs early. Steady combinations of all three pins check domain independence: a stop wired into the wrong domain would silence the free-running clock or the processor pair.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        PWR_OFF    = 2'd0,
        PWR_SETTLE = 2'd1,
        PWR_ON     = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic osc_on;
        logic run_ok;
    } pwr_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync import clkstop_pkg::*; #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = SYNC_STAGES,
    parameter bit          RST_BIT = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stg[g] <= {WIDTH{RST_BIT}};
            end else begin
                if (g == 0) stg[g] <= d_i;
                else        stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cs_pwr_seq.sv
module cs_pwr_seq import clkstop_pkg::*; #(
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     pwr_dn_ni,
    output pwr_ctl_t ctl_o
);

    localparam int unsigned CW = cnt_width(SETTLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic       pd_run;
    pwr_state_e st_q;
    logic [CW-1:0] cnt_q;

    cs_sync #(.WIDTH(1), .RST_BIT(1'b0)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pwr_dn_ni),
        .q_o   (pd_run)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || !pd_run) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PWR_OFF: begin
                    st_q  <= PWR_SETTLE;
                    cnt_q <= '0;
                end
                PWR_SETTLE: begin
                    if (cnt_q == LAST) st_q <= PWR_ON;
                    else               cnt_q <= cnt_q + 1'b1;
                end
                PWR_ON:  st_q <= PWR_ON;
                default: st_q <= PWR_OFF;
            endcase
        end
    end

    always_comb begin
        ctl_o.osc_on = (st_q != PWR_OFF);
        ctl_o.run_ok = (st_q == PWR_ON);
    end

endmodule

// File: rtl/cs_gate.sv
module cs_gate import clkstop_pkg::*; #(
    parameter int unsigned N_OUT = 1,
    parameter int unsigned N_REQ = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_REQ-1:0] run_req_i,
    output logic [N_OUT-1:0] clk_o
);

    logic [N_REQ-1:0] run_sync;
    logic             en_q;

    cs_sync #(.WIDTH(N_REQ), .RST_BIT(1'b0)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (run_req_i),
        .q_o   (run_sync)
    );

    // Enable moves on the falling edge, so it only changes in the low phase.
    always_ff @(negedge clk_i) begin
        if (rst_i) en_q <= 1'b0;
        else       en_q <= &run_sync;
    end

    assign clk_o = {N_OUT{clk_i & en_q}};

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl import clkstop_pkg::*; #(
    parameter int unsigned N_CPU      = 2,
    parameter int unsigned N_PCI      = 5,
    parameter int unsigned N_REF      = 2,
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic             clk_cpu_i,
    input  logic             clk_pci_i,
    input  logic             clk_ref_i,
    input  logic             clk_usb_i,
    input  logic             rst_i,
    input  logic             cpu_stop_ni,
    input  logic             pci_stop_ni,
    input  logic             pwr_dn_ni,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic [N_REF-1:0] ref_clk_o,
    output logic             usb_clk_o,
    output logic             osc_en_o,
    output logic             pll_en_o
);

    pwr_ctl_t pctl;

    cs_pwr_seq #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
        .clk_i     (clk_ref_i),
        .rst_i     (rst_i),
        .pwr_dn_ni (pwr_dn_ni),
        .ctl_o     (pctl)
    );

    cs_gate #(.N_OUT(N_CPU), .N_REQ(2)) u_cpu (
        .clk_i     (clk_cpu_i),
        .rst_i     (rst_i),
        .run_req_i ({cpu_stop_ni, pctl.run_ok}),
        .clk_o     (cpu_clk_o)
    );

    cs_gate #(.N_OUT(N_PCI), .N_REQ(2)) u_pci (
        .clk_i     (clk_pci_i),
        .rst_i     (rst_i),
        .run_req_i ({pci_stop_ni, pctl.run_ok}),
        .clk_o     (pci_clk_o)
    );

    cs_gate #(.N_OUT(1), .N_REQ(1)) u_free (
        .clk_i     (clk_pci_i),
        .rst_i     (rst_i),
        .run_req_i (pctl.run_ok),
        .clk_o     (pci_free_o)
    );

    cs_gate #(.N_OUT(N_REF), .N_REQ(1)) u_ref (
        .clk_i     (clk_ref_i),
        .rst_i     (rst_i),
        .run_req_i (pctl.run_ok),
        .clk_o     (ref_clk_o)
    );

    cs_gate #(.N_OUT(1), .N_REQ(1)) u_usb (
        .clk_i     (clk_usb_i),
        .rst_i     (rst_i),
        .run_req_i (pctl.run_ok),
        .clk_o     (usb_clk_o)
    );

    assign osc_en_o = pctl.osc_on;
    assign pll_en_o = pctl.osc_on;

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int unsigned N_CPU      = 2,
    parameter int unsigned N_PCI      = 5,
    parameter int unsigned N_REF      = 2,
    parameter int unsigned SETTLE_CYC = 16
) (
    input logic             clk_cpu_i,
    input logic             clk_pci_i,
    input logic             clk_ref_i,
    input logic             rst_i,
    input logic             cpu_stop_ni,
    input logic             pci_stop_ni,
    input logic             pwr_dn_ni,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pci_free_o,
    input logic [N_REF-1:0] ref_clk_o,
    input logic             osc_en_o,
    input logic             pll_en_o
);

    int unsigned on_cnt;
    logic [2:0]  off_run;

    always_ff @(posedge clk_ref_i) begin
        if (rst_i) begin
            on_cnt  <= 0;
            off_run <= 3'd7;
        end else if (!osc_en_o) begin
            on_cnt <= 0;
            if (off_run != 3'd7) off_run <= off_run + 3'd1;
        end else if (on_cnt < SETTLE_CYC + 3) begin
            on_cnt <= on_cnt + 1;
        end else begin
            off_run <= 3'd0;
        end
    end

    AST_RST_QUIET: assert property (@(negedge clk_ref_i)
        (rst_i && $past(rst_i)) |-> (ref_clk_o == '0 && !osc_en_o && !pll_en_o)); // R1

    AST_CPU_STOP_LOW: assert property (@(negedge clk_cpu_i) disable iff (rst_i)
        (!cpu_stop_ni && $past(!cpu_stop_ni) && $past(!cpu_stop_ni, 2) && $past(!cpu_stop_ni, 3))
        |-> cpu_clk_o == '0); // R2

    AST_PCI_STOP_LOW: assert property (@(negedge clk_pci_i) disable iff (rst_i)
        (!pci_stop_ni && $past(!pci_stop_ni) && $past(!pci_stop_ni, 2) && $past(!pci_stop_ni, 3))
        |-> pci_clk_o == '0); // R3

    AST_PD_OSC_OFF: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        $past(!pwr_dn_ni, 3) |-> (!osc_en_o && !pll_en_o)); // R4

    AST_PD_REF_LOW: assert property (@(negedge clk_ref_i) disable iff (rst_i)
        (!osc_en_o && $past(!osc_en_o) && $past(!osc_en_o, 2) && $past(!osc_en_o, 3))
        |-> ref_clk_o == '0); // R4

    AST_SETTLE_HOLD: assert property (@(negedge clk_ref_i) disable iff (rst_i)
        (osc_en_o && on_cnt <= SETTLE_CYC && off_run >= 3'd4) |-> ref_clk_o == '0); // R7

    AST_FREE_WITH_PCI: assert property (@(negedge clk_pci_i) disable iff (rst_i)
        (pci_clk_o != '0) |-> pci_free_o); // R8

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk_cpu_i   (clk_cpu_i),
    .clk_pci_i   (clk_pci_i),
    .clk_ref_i   (clk_ref_i),
    .rst_i       (rst_i),
    .cpu_stop_ni (cpu_stop_ni),
    .pci_stop_ni (pci_stop_ni),
    .pwr_dn_ni   (pwr_dn_ni),
    .cpu_clk_o   (cpu_clk_o),
    .pci_clk_o   (pci_clk_o),
    .pci_free_o  (pci_free_o),
    .ref_clk_o   (ref_clk_o),
    .osc_en_o    (osc_en_o),
    .pll_en_o    (pll_en_o)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;

    localparam int N_CPU  = 2;
    localparam int N_PCI  = 5;
    localparam int N_REF  = 2;
    localparam int SETTLE = 16;
    localparam real REF_P = 14.0;
    localparam int NMON   = 7;

    logic clk_cpu = 0, clk_pci = 0, clk_ref = 0, clk_usb = 0;
    logic rst = 1;
    logic cpu_stop_n = 1, pci_stop_n = 1, pwr_dn_n = 1;
    logic [N_CPU-1:0] cpu_o;
    logic [N_PCI-1:0] pci_o;
    logic [N_REF-1:0] ref_o;
    logic free_o, usb_o, osc_en, pll_en;

    always #2 clk_cpu = ~clk_cpu;
    initial begin #1;   forever #6 clk_pci = ~clk_pci; end
    initial begin #3;   forever #7 clk_ref = ~clk_ref; end
    initial begin #0.5; forever #3 clk_usb = ~clk_usb; end

    clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF), .SETTLE_CYC(SETTLE)) u0 (
        .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_ref_i(clk_ref), .clk_usb_i(clk_usb),
        .rst_i(rst), .cpu_stop_ni(cpu_stop_n), .pci_stop_ni(pci_stop_n), .pwr_dn_ni(pwr_dn_n),
        .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pci_free_o(free_o), .ref_clk_o(ref_o),
        .usb_clk_o(usb_o), .osc_en_o(osc_en), .pll_en_o(pll_en)
    );

    // monitor index: 0,1 cpu pair; 2,3 gated bus; 4 free bus; 5 reference; 6 serial-bus
    logic [NMON-1:0] mon, prev;
    assign mon = {usb_o, ref_o[0], free_o, pci_o[N_PCI-1], pci_o[0], cpu_o[1], cpu_o[0]};

    function automatic real half_of(input int i);
        case (i)
            0, 1:    return 2.0;
            2, 3, 4: return 6.0;
            5:       return 7.0;
            default: return 3.0;
        endcase
    endfunction

    int  rises [NMON];
    real last_edge [NMON];
    int  pw_chk = 0, pw_bad = 0;

    initial begin
        prev = '0;
        for (int i = 0; i < NMON; i++) begin rises[i] = 0; last_edge[i] = -1.0; end
    end

    always @(mon) begin
        for (int i = 0; i < NMON; i++) begin
            if (mon[i] !== prev[i]) begin
                if (mon[i] === 1'b1) rises[i]++;
                if (last_edge[i] >= 0.0) begin
                    pw_chk++;
                    if ($realtime - last_edge[i] < half_of(i) - 0.001) begin
                        pw_bad++;
                        $display("FAIL R6 monitor %0d pulse: actual %0t expected >= %0t",
                                 i, $realtime - last_edge[i], half_of(i));
                    end
                end
                last_edge[i] = $realtime;
            end
        end
        prev = mon;
    end

    int nchk = 0, nbad = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_run(input int i, input bit c, input bit p, input bit d);
        if (!d) return 1'b0;
        if (i < 2) return c;
        if (i < 4) return p;
        return 1'b1;
    endfunction

    function automatic string tag_of(input int i);
        if (!pwr_dn_n) return "R4";
        if (i < 2 && !cpu_stop_n) return "R2";
        if ((i == 2 || i == 3) && !pci_stop_n) return "R3";
        if (!cpu_stop_n || !pci_stop_n) return "R8";
        return "R5";
    endfunction

    task automatic window_check();
        int snap [NMON];
        snap = rises;
        #120;
        for (int i = 0; i < NMON; i++) begin
            int d;
            bit e;
            d = rises[i] - snap[i];
            e = exp_run(i, cpu_stop_n, pci_stop_n, pwr_dn_n);
            chk(e ? (d > 0) : (d == 0), tag_of(i), $sformatf("monitor %0d rising edges", i), d, e ? 1 : 0);
        end
        chk(osc_en == pwr_dn_n && pll_en == pwr_dn_n, "R4", "osc/pll enables",
            {osc_en, pll_en}, {pwr_dn_n, pwr_dn_n});
    endtask

    task automatic settle_check(input string what);
        real t0, t_ref, t_cpu;
        int  r_ref, r_cpu;
        @(posedge osc_en);
        t0 = $realtime;
        #0.25;
        r_ref = rises[5]; r_cpu = rises[0];
        t_ref = -1.0; t_cpu = -1.0;
        for (int k = 0; k < 1000 && (t_ref < 0.0 || t_cpu < 0.0); k++) begin
            #1;
            if (t_ref < 0.0 && rises[5] != r_ref) t_ref = $realtime;
            if (t_cpu < 0.0 && rises[0] != r_cpu) t_cpu = $realtime;
        end
        chk(t_ref >= t0 + SETTLE * REF_P, "R7", {what, " ref hold ns"},
            int'(t_ref - t0), int'(SETTLE * REF_P));
        chk(t_cpu >= t0 + SETTLE * REF_P, "R7", {what, " cpu hold ns"},
            int'(t_cpu - t0), int'(SETTLE * REF_P));
    endtask

    task automatic set_pins(input bit c, input bit p, input bit d);
        cpu_stop_n = c; pci_stop_n = p; pwr_dn_n = d;
    endtask

    initial begin : watchdog
        #200us;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + pw_chk + 1, nbad + pw_bad + 1);
        $finish;
    end

    initial begin : main
        int snap [NMON];
        void'($urandom(32'h5EED_C10C));
        #40.25;
        // R1: quiet under reset
        snap = rises;
        #50;
        for (int i = 0; i < NMON; i++)
            chk(rises[i] == snap[i], "R1", $sformatf("monitor %0d edges in reset", i), rises[i] - snap[i], 0);
        chk(!osc_en && !pll_en, "R1", "enables in reset", {osc_en, pll_en}, 0);
        #10 rst = 0;
        settle_check("power-up");

        // directed: every pin combination
        for (int m = 7; m >= 0; m--) begin
            set_pins(m[2], m[1], m[0]);
            #450;
            window_check();
        end

        // R7 corner: power-down again in the middle of settling
        set_pins(1, 1, 0);
        #300 pwr_dn_n = 1;
        #100 pwr_dn_n = 0;
        #150 pwr_dn_n = 1;
        settle_check("re-entry");
        #300;
        window_check();

        // random pin toggles at arbitrary clock phases (R6 monitored throughout)
        for (int n = 0; n < 60; n++) begin
            int sel;
            sel = $urandom_range(0, 2);
            case (sel)
                0: begin cpu_stop_n = ~cpu_stop_n; #($urandom_range(30, 150)); end
                1: begin pci_stop_n = ~pci_stop_n; #($urandom_range(30, 150)); end
                default: begin pwr_dn_n = ~pwr_dn_n; #($urandom_range(120, 300)); end
            endcase
        end

        // random steady combinations
        for (int n = 0; n < 6; n++) begin
            set_pins(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
            #450;
            window_check();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk + pw_chk, nbad + pw_bad);
        $finish;
    end

endmodule